// File: doc/BRIEF.md
# Privilege and Illegal-Operation Trap Controller

This block holds the per-instruction exception logic of a simple in-order core. Each time the core strobes an instruction into execution, the block gets the decoded operation class, a flag for the top bit of the special-register number, an illegal-instruction flag, the instruction address and the current machine state word. From these it works out whether the instruction has to trap. It then produces the next fetch address, the new state word and the contents of two save registers.

There are two trap causes: a privileged operation run in user mode, and an illegal instruction. Both send the next fetch to one fixed vector. The first save register receives the faulting address. The second save register receives the state word as it was before the trap, with one cause bit set in it. The live state word is forced into a fixed supervisor configuration. A halt operation that does not trap sets a sticky halted flag, and the block then ignores every later strobe until reset. All registered outputs change only at a clock edge where the strobe is high.

Top module: `trap_ctl`

## Requirements
- R1: The privileged operation classes are halt (1), read-state (2), write-state (3), write-state-doubleword (4) and return-from-interrupt (5). A privileged operation strobed while `curMsr[14]` (user mode) is 1 traps with `trapCause` = 2'b01.
- R2: Read-special (6) and write-special (7) are privileged only when `sprHigh` is 1. With `sprHigh` = 0 they never cause a privilege trap.
- R3: On a trap, `nextPc` becomes `VECTOR` (default 0x700) for either cause. `trapCause` is 2'b01 for privilege and 2'b10 for illegal, and it is never 2'b11.
- R4: On a trap, `saveAddr` takes `curPc`. `saveMsr` takes `curMsr` with bit 18 set for a privilege trap, or with bit 19 set for an illegal trap.
- R5: On a trap, `msrOut` is `curMsr` with bits 1, 2, 4, 5, 8, 11, 13, 14, 15, 23, 25, 32, 33 and 34 cleared and bits 0 and 63 set.
- R6: A halt operation that does not trap sets `halted`, which stays set until reset. While `halted` is 1, strobes change no output.
- R7: A strobed instruction that does not trap gives `nextPc` = `curPc` + 4, `msrOut` = `curMsr` and `trapCause` = 0. It leaves `saveAddr` and `saveMsr` unchanged.
- R8: The checks have a fixed priority: privilege violation first, then halt, then illegal. An illegal privileged operation in user mode reports cause 2'b01. A halt with the illegal flag set, in supervisor mode, halts without trapping.
- R9: After reset every output is zero.
- R10: In cycles without the strobe, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| execValid | input | 1 | Execute strobe for the presented instruction |
| opClass | input | 3 | Decoded operation class (codes in R1, R2; 0 = ordinary) |
| sprHigh | input | 1 | Top bit of the special-register number |
| illegalOp | input | 1 | Decoder marks the instruction illegal |
| curPc | input | ADDR_W | Address of the presented instruction |
| curMsr | input | 64 | Machine state word before this instruction |
| nextPc | output | ADDR_W | Next fetch address |
| msrOut | output | 64 | Machine state word after this instruction |
| saveAddr | output | ADDR_W | Saved return address |
| saveMsr | output | 64 | Saved state word with cause bit |
| trapCause | output | 2 | Cause of the last strobed instruction |
| halted | output | 1 | Sticky halted flag |

## Verification
The hardest situation to reach is the frozen state after a halt. It needs a halt operation in supervisor mode, and every strobe after it must then leave the outputs alone. Only a reset gets out of it, so the stimulus mixes directed halts with a random instruction stream that is periodically reset. The bench also drives collisions on purpose: a privileged operation in user mode with the illegal flag set, and a halt with the illegal flag set. These exercise the priority order.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;

  localparam int unsigned MSR_W = 64;

  typedef enum logic [2:0] {
    OP_PLAIN  = 3'd0,
    OP_HALT   = 3'd1,
    OP_RDMSR  = 3'd2,
    OP_WRMSR  = 3'd3,
    OP_WRMSRD = 3'd4,
    OP_RETINT = 3'd5,
    OP_RDSPR  = 3'd6,
    OP_WRSPR  = 3'd7
  } opClassT;

  typedef struct packed {
    logic commit;
    logic takeTrap;
    logic causePriv;
    logic causeIllegal;
  } stepCtlT;

  // state word bit positions (bit 0 = least significant)
  localparam int unsigned B_LE    = 0;
  localparam int unsigned B_RI    = 1;
  localparam int unsigned B_PMM   = 2;
  localparam int unsigned B_DR    = 4;
  localparam int unsigned B_IR    = 5;
  localparam int unsigned B_FE1   = 8;
  localparam int unsigned B_FE0   = 11;
  localparam int unsigned B_FP    = 13;
  localparam int unsigned B_USER  = 14;
  localparam int unsigned B_EE    = 15;
  localparam int unsigned B_CPRIV = 18;
  localparam int unsigned B_CILL  = 19;
  localparam int unsigned B_VSX   = 23;
  localparam int unsigned B_VEC   = 25;
  localparam int unsigned B_TM    = 32;
  localparam int unsigned B_TS0   = 33;
  localparam int unsigned B_TS1   = 34;
  localparam int unsigned B_SF    = 63;

  function automatic logic [MSR_W-1:0] bitAt(input int unsigned pos);
    logic [MSR_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic logic [MSR_W-1:0] trapClearMask();
    return bitAt(B_RI) | bitAt(B_PMM) | bitAt(B_DR) | bitAt(B_IR) |
           bitAt(B_FE1) | bitAt(B_FE0) | bitAt(B_FP) | bitAt(B_USER) |
           bitAt(B_EE) | bitAt(B_VSX) | bitAt(B_VEC) | bitAt(B_TM) |
           bitAt(B_TS0) | bitAt(B_TS1);
  endfunction

  function automatic logic [MSR_W-1:0] trapSetMask();
    return bitAt(B_SF) | bitAt(B_LE);
  endfunction

endpackage

// File: rtl/trap_ctl_ctrl.sv
module trap_ctl_ctrl
  import trap_ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    execValid,
  input  opClassT opClass,
  input  logic    sprHigh,
  input  logic    illegalOp,
  input  logic    userMode,
  output stepCtlT stepCtl,
  output logic    haltedQ
);

  logic isPriv;
  logic live;
  logic privFault;
  logic haltNow;
  logic illFault;

  always_comb begin
    unique case (opClass)
      OP_HALT, OP_RDMSR, OP_WRMSR, OP_WRMSRD, OP_RETINT: isPriv = 1'b1;
      OP_RDSPR, OP_WRSPR:                                isPriv = sprHigh;
      default:                                           isPriv = 1'b0;
    endcase
  end

  assign live      = execValid && !haltedQ;
  assign privFault = live && isPriv && userMode;
  assign haltNow   = live && !privFault && (opClass == OP_HALT);
  assign illFault  = live && !privFault && !haltNow && illegalOp;

  always_comb begin
    stepCtl              = '0;
    stepCtl.commit       = live;
    stepCtl.takeTrap     = privFault || illFault;
    stepCtl.causePriv    = privFault;
    stepCtl.causeIllegal = illFault;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) haltedQ <= 1'b0;
    else if (haltNow) haltedQ <= 1'b1;
  end

endmodule

// File: rtl/trap_ctl_dp.sv
module trap_ctl_dp
  import trap_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter logic [ADDR_W-1:0] VECTOR = 'h700
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtlT           stepCtl,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [MSR_W-1:0]  curMsr,
  output logic [ADDR_W-1:0] nextPc,
  output logic [MSR_W-1:0]  msrOut,
  output logic [ADDR_W-1:0] saveAddr,
  output logic [MSR_W-1:0]  saveMsr,
  output logic [1:0]        trapCause
);

  localparam logic [MSR_W-1:0]  CLR_MASK = trapClearMask();
  localparam logic [MSR_W-1:0]  SET_MASK = trapSetMask();
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(4);

  logic [MSR_W-1:0] forcedMsr;
  logic [MSR_W-1:0] causeBits;

  for (genvar i = 0; i < MSR_W; i++) begin : g_force
    if (SET_MASK[i]) begin : g_set
      assign forcedMsr[i] = 1'b1;
    end else if (CLR_MASK[i]) begin : g_clr
      assign forcedMsr[i] = 1'b0;
    end else begin : g_keep
      assign forcedMsr[i] = curMsr[i];
    end
  end

  always_comb begin
    causeBits = '0;
    causeBits[B_CPRIV] = stepCtl.causePriv;
    causeBits[B_CILL]  = stepCtl.causeIllegal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPc    <= '0;
      msrOut    <= '0;
      saveAddr  <= '0;
      saveMsr   <= '0;
      trapCause <= '0;
    end else if (stepCtl.commit) begin
      trapCause <= {stepCtl.causeIllegal, stepCtl.causePriv};
      if (stepCtl.takeTrap) begin
        nextPc   <= VECTOR;
        msrOut   <= forcedMsr;
        saveAddr <= curPc;
        saveMsr  <= curMsr | causeBits;
      end else begin
        nextPc   <= curPc + STEP;
        msrOut   <= curMsr;
      end
    end
  end

endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
  import trap_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter logic [ADDR_W-1:0] VECTOR = 'h700
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              execValid,
  input  logic [2:0]        opClass,
  input  logic              sprHigh,
  input  logic              illegalOp,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [63:0]       curMsr,
  output logic [ADDR_W-1:0] nextPc,
  output logic [63:0]       msrOut,
  output logic [ADDR_W-1:0] saveAddr,
  output logic [63:0]       saveMsr,
  output logic [1:0]        trapCause,
  output logic              halted
);

  stepCtlT stepCtl;

  trap_ctl_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .execValid (execValid),
    .opClass   (opClassT'(opClass)),
    .sprHigh   (sprHigh),
    .illegalOp (illegalOp),
    .userMode  (curMsr[B_USER]),
    .stepCtl   (stepCtl),
    .haltedQ   (halted)
  );

  trap_ctl_dp #(.ADDR_W(ADDR_W), .VECTOR(VECTOR)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stepCtl   (stepCtl),
    .curPc     (curPc),
    .curMsr    (curMsr),
    .nextPc    (nextPc),
    .msrOut    (msrOut),
    .saveAddr  (saveAddr),
    .saveMsr   (saveMsr),
    .trapCause (trapCause)
  );

endmodule

// File: rtl/trap_ctl_chk.sv
module trap_ctl_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter logic [ADDR_W-1:0] VECTOR = 'h700
) (
  input logic              clk,
  input logic              rstN,
  input logic              execValid,
  input logic [2:0]        opClass,
  input logic              sprHigh,
  input logic              illegalOp,
  input logic [ADDR_W-1:0] curPc,
  input logic [63:0]       curMsr,
  input logic [ADDR_W-1:0] nextPc,
  input logic [63:0]       msrOut,
  input logic [ADDR_W-1:0] saveAddr,
  input logic [63:0]       saveMsr,
  input logic [1:0]        trapCause,
  input logic              halted
);

  logic fixedPriv;
  logic anyPriv;
  assign fixedPriv = (opClass >= 3'd1) && (opClass <= 3'd5);
  assign anyPriv   = fixedPriv || (opClass >= 3'd6 && sprHigh);

  // R1
  a_r1_priv_trap: assert property (@(posedge clk) disable iff (!rstN)
    execValid && !halted && fixedPriv && curMsr[14]
    |=> trapCause == 2'b01 && nextPc == VECTOR);

  // R2
  a_r2_spr_low_free: assert property (@(posedge clk) disable iff (!rstN)
    execValid && !halted && opClass >= 3'd6 && !sprHigh && !illegalOp
    |=> trapCause == 2'b00);

  // R3
  a_r3_cause_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trapCause));

  // R4
  a_r4_save_addr: assert property (@(posedge clk) disable iff (!rstN)
    execValid && !halted && anyPriv && curMsr[14]
    |=> saveAddr == $past(curPc) && saveMsr[18]);

  // R5
  a_r5_forced_state: assert property (@(posedge clk) disable iff (!rstN)
    execValid && !halted && anyPriv && curMsr[14]
    |=> !msrOut[14] && msrOut[63] && msrOut[0]);

  // R6
  a_r6_sticky_halt: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R6
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(nextPc) && $stable(msrOut) && $stable(trapCause));

  // R7
  a_r7_step: assert property (@(posedge clk) disable iff (!rstN)
    execValid && !halted && !illegalOp && !(anyPriv && curMsr[14])
    |=> nextPc == $past(curPc) + ADDR_W'(4) && trapCause == 2'b00);

  // R10
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !execValid |=> $stable(nextPc) && $stable(saveAddr) && $stable(saveMsr));

endmodule

bind trap_ctl trap_ctl_chk #(.ADDR_W(ADDR_W), .VECTOR(VECTOR)) chk_i (
  .clk(clk), .rstN(rstN), .execValid(execValid), .opClass(opClass),
  .sprHigh(sprHigh), .illegalOp(illegalOp), .curPc(curPc), .curMsr(curMsr),
  .nextPc(nextPc), .msrOut(msrOut), .saveAddr(saveAddr), .saveMsr(saveMsr),
  .trapCause(trapCause), .halted(halted)
);

// File: tb/trap_ctl_tb_top.sv
module trap_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        execValid = 1'b0;
  logic [2:0]  opClass = '0;
  logic        sprHigh = 1'b0;
  logic        illegalOp = 1'b0;
  logic [63:0] curPc = '0;
  logic [63:0] curMsr = '0;
  logic [63:0] nextPc, msrOut, saveAddr, saveMsr;
  logic [1:0]  trapCause;
  logic        halted;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  trap_ctl dut_i (
    .clk(clk), .rstN(rstN), .execValid(execValid), .opClass(opClass),
    .sprHigh(sprHigh), .illegalOp(illegalOp), .curPc(curPc), .curMsr(curMsr),
    .nextPc(nextPc), .msrOut(msrOut), .saveAddr(saveAddr), .saveMsr(saveMsr),
    .trapCause(trapCause), .halted(halted)
  );

  // reference model state
  logic [63:0] mPc, mMsr, mSa, mSm;
  logic [1:0]  mCause;
  bit          mHalt;

  function automatic logic [63:0] clrBits();
    logic [63:0] m = '0;
    int pos[14] = '{1, 2, 4, 5, 8, 11, 13, 14, 15, 23, 25, 32, 33, 34};
    foreach (pos[k]) m[pos[k]] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] forced(input logic [63:0] m);
    return (m & ~clrBits()) | 64'h8000_0000_0000_0001;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPc = 0; mMsr = 0; mSa = 0; mSm = 0; mCause = 0; mHalt = 0;
    end else if (execValid && !mHalt) begin
      bit priv;
      priv = (opClass inside {[1:5]}) || (opClass >= 6 && sprHigh);
      if (priv && curMsr[14]) begin
        mPc = 64'h700; mSa = curPc; mSm = curMsr | (64'd1 << 18);
        mMsr = forced(curMsr); mCause = 2'b01;
      end else if (opClass == 3'd1) begin
        mHalt = 1; mPc = curPc + 4; mMsr = curMsr; mCause = 0;
      end else if (illegalOp) begin
        mPc = 64'h700; mSa = curPc; mSm = curMsr | (64'd1 << 19);
        mMsr = forced(curMsr); mCause = 2'b10;
      end else begin
        mPc = curPc + 4; mMsr = curMsr; mCause = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3/R7 nextPc", nextPc, mPc);
      chk("R5 msrOut", msrOut, mMsr);
      chk("R4 saveAddr", saveAddr, mSa);
      chk("R4 saveMsr", saveMsr, mSm);
      chk("R8 trapCause", {62'd0, trapCause}, {62'd0, mCause});
      chk("R6 halted", {63'd0, halted}, {63'd0, mHalt});
    end
  end

  task automatic issue(input logic [2:0] op, input bit sh, input bit il,
                       input logic [63:0] pc, input logic [63:0] msr);
    @(negedge clk);
    execValid = 1; opClass = op; sprHigh = sh; illegalOp = il;
    curPc = pc; curMsr = msr;
    @(negedge clk);
    execValid = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  localparam logic [63:0] USER = 64'h0000_0000_0000_4000;
  localparam logic [63:0] MIX  = 64'hF0F0_1234_0FFF_C03F;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R9 nextPc reset", nextPc, 0);
    chk("R9 msrOut reset", msrOut, 0);
    chk("R9 halted reset", {63'd0, halted}, 0);

    issue(3'd0, 0, 0, 64'h1000, MIX & ~USER);
    chk("R7 plain step", nextPc, 64'h1004);
    chk("R7 state pass", msrOut, MIX & ~USER);

    issue(3'd7, 0, 0, 64'h2000, USER);
    chk("R2 spr low no trap", {62'd0, trapCause}, 0);
    chk("R2 spr low step", nextPc, 64'h2004);

    issue(3'd6, 1, 0, 64'h2100, USER);
    chk("R2 spr high traps", {62'd0, trapCause}, 2'b01);

    issue(3'd2, 0, 0, 64'h3000, MIX);
    chk("R1 rdmsr user trap", {62'd0, trapCause}, 2'b01);
    chk("R3 vector", nextPc, 64'h700);
    chk("R4 save addr", saveAddr, 64'h3000);
    chk("R4 save msr priv bit", saveMsr, MIX | (64'd1 << 18));
    chk("R5 forced msr", msrOut, (MIX & ~64'h0000_0007_0280_E936) | 64'h8000_0000_0000_0001);

    repeat (3) @(negedge clk);
    chk("R10 idle hold pc", nextPc, 64'h700);
    chk("R10 idle hold save", saveAddr, 64'h3000);

    issue(3'd0, 0, 1, 64'h4000, 64'h0);
    chk("R3 illegal cause", {62'd0, trapCause}, 2'b10);
    chk("R4 save msr illegal bit", saveMsr, 64'd1 << 19);

    issue(3'd4, 0, 1, 64'h4100, USER);
    chk("R8 priv over illegal", {62'd0, trapCause}, 2'b01);

    issue(3'd1, 0, 0, 64'h4200, USER);
    chk("R8 halt in user traps", {62'd0, trapCause}, 2'b01);
    chk("R8 no halt in user", {63'd0, halted}, 0);

    issue(3'd1, 0, 1, 64'h5000, 64'h0);
    chk("R8 halt over illegal", {62'd0, trapCause}, 0);
    chk("R6 halted set", {63'd0, halted}, 1);
    chk("R6 halt step", nextPc, 64'h5004);

    issue(3'd0, 0, 1, 64'h6000, USER);
    chk("R6 frozen pc", nextPc, 64'h5004);
    chk("R6 frozen cause", {62'd0, trapCause}, 0);

    doReset();
    @(negedge clk);
    chk("R9 halt cleared", {63'd0, halted}, 0);

    // random back-to-back stream, reset now and then
    for (int n = 0; n < 3000; n++) begin
      if (n % 200 == 199) doReset();
      @(negedge clk);
      execValid = ($urandom % 4) != 0;
      opClass   = (($urandom % 8) == 0) ? 3'd1 : 3'($urandom % 8 == 1 ? 0 : $urandom);
      sprHigh   = $urandom;
      illegalOp = ($urandom % 5) == 0;
      curPc     = {$urandom, $urandom} & ~64'h3;
      curMsr    = {$urandom, $urandom};
    end
    @(negedge clk);
    execValid = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule